// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core with Split Control Decode

This block is a small 32-bit processor core that finishes every instruction in one clock. It reads its instruction combinationally from an instruction-memory port addressed by the program counter. Loads and stores go through a separate data-memory port with a combinational read and a write strobe that is committed on the next rising edge. The core contains the program counter, a register file with a hard-wired zero register, an immediate extender, an ALU and two control decoders.

Control is decoded in two levels. A main decoder looks only at the 6-bit opcode and produces the datapath steering plus a 3-bit ALU-class code. A local decoder turns that class code into a 3-bit ALU operation. For register-register instructions it uses the low four bits of the function field to pick the operation. The supported set is register add, subtract, and, or and set-less-than, plus or-immediate, load word, store word, branch-if-equal and jump.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0. Each instruction other than a taken branch or a jump advances `imem_addr` by 4 on the next rising edge.
- R2: Opcode 000000 selects a register operation on rs (bits 25:21) and rt (bits 20:16), written to rd (bits 15:11). The function codes are 100000 add, 100010 subtract, 100100 and, 100101 or, and 101010 set-less-than. Set-less-than produces the same result as subtract, rs minus rt.
- R3: For register operations only function bits 3:0 select the operation. Function bits 5:4 have no effect, so 010000 adds and 000010 subtracts.
- R4: Opcode 001101 (or-immediate) writes rs OR the zero-extended 16-bit immediate (bits 15:0) into rt.
- R5: Opcode 100011 (load) writes into rt the `dmem_rdata` word read at address rs plus the sign-extended immediate. The data memory keeps its contents.
- R6: Opcode 101011 (store) raises `dmem_we` for that one cycle, with `dmem_addr` = rs + sign-extended immediate and `dmem_wdata` = rt. It writes no register. `dmem_we` is low for every other opcode and during reset.
- R7: Opcode 000100 (branch if equal) loads PC+4 plus the sign-extended immediate shifted left by 2 when rs equals rt. Otherwise it loads PC+4. It writes no register.
- R8: Opcode 000010 (jump) loads PC+4 bits 31:28 followed by instruction bits 25:0 and then two zero bits. It writes no register.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: The main decoder sets ALU-class bit 2 for opcode 000000 only. With bit 2 clear, the class alone selects the ALU operation: or for or-immediate, add for load and store, subtract for branch. Internally the ALU operation codes are add 000, subtract 001, and 010, or 110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address for load or store (ALU result) |
| dmem_wdata | output | 32 | Store data (rt value) |
| dmem_we | output | 1 | Store strobe, committed at the next rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |

## Verification
The bench targets the following cases:
- An or-immediate with bit 15 set. A core that sign-extended it would leave ones in the upper half of the stored result.
- A load with a negative offset. A zero-extending core would fetch from far outside the table.
- Function codes with bits 5:4 changed. A decoder that used the whole field would fall into its default operation.
- A taken forward branch, an untaken branch and a one-word backward self-loop, covering the offset scaling and the PC+4 base.
- A jump whose skipped words hold poison writes.
- A write aimed at register 0, which must read back as zero when stored.

Every cycle is compared in lockstep with an instruction-level model, and the final data memory is compared with it too.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JMP   = 6'b000010;

    // low nibble of the function field; bits 5:4 are not decoded
    localparam logic [3:0] FN_ADD = 4'b0000;
    localparam logic [3:0] FN_SUB = 4'b0010;
    localparam logic [3:0] FN_AND = 4'b0100;
    localparam logic [3:0] FN_OR  = 4'b0101;
    localparam logic [3:0] FN_SLT = 4'b1010;

    // ALU-class codes between main and local decoder
    localparam logic [2:0] ACLS_RTYPE = 3'b100;
    localparam logic [2:0] ACLS_ORI   = 3'b010;
    localparam logic [2:0] ACLS_MEM   = 3'b000;
    localparam logic [2:0] ACLS_BEQ   = 3'b001;

    typedef enum logic [2:0] {
        ALU_ADD = 3'b000,
        ALU_SUB = 3'b001,
        ALU_AND = 3'b010,
        ALU_OR  = 3'b110
    } alu_fn_e;

    typedef enum logic [1:0] {
        NPC_SEQ = 2'b00,
        NPC_BR  = 2'b01,
        NPC_JMP = 2'b10
    } npc_sel_e;

    typedef struct packed {
        logic       dst_is_rd;
        logic       opb_is_imm;
        logic       imm_signed;
        logic       wb_from_mem;
        logic       reg_we;
        logic       mem_we;
        npc_sel_e   npc_sel;
        logic [2:0] alu_cls;
    } ctrl_t;

endpackage

// File: rtl/main_decoder.sv
module main_decoder
    import core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{dst_is_rd: 1'b0, opb_is_imm: 1'b0, imm_signed: 1'b0,
                 wb_from_mem: 1'b0, reg_we: 1'b0, mem_we: 1'b0,
                 npc_sel: NPC_SEQ, alu_cls: ACLS_MEM};
        case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.alu_cls   = ACLS_RTYPE;
            end
            OPC_ORI: begin
                ctrl.opb_is_imm = 1'b1;
                ctrl.reg_we     = 1'b1;
                ctrl.alu_cls    = ACLS_ORI;
            end
            OPC_LOAD: begin
                ctrl.opb_is_imm  = 1'b1;
                ctrl.imm_signed  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_we      = 1'b1;
            end
            OPC_STORE: begin
                ctrl.opb_is_imm = 1'b1;
                ctrl.imm_signed = 1'b1;
                ctrl.mem_we     = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.imm_signed = 1'b1;
                ctrl.npc_sel    = NPC_BR;
                ctrl.alu_cls    = ACLS_BEQ;
            end
            OPC_JMP: begin
                ctrl.npc_sel = NPC_JMP;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_decoder.sv
module alu_decoder
    import core_pkg::*;
(
    input  logic [2:0] alu_cls,
    input  logic [3:0] func_lo,
    output alu_fn_e    alu_fn
);

    always_comb begin
        if (alu_cls[2]) begin
            case (func_lo)
                FN_ADD:  alu_fn = ALU_ADD;
                FN_SUB:  alu_fn = ALU_SUB;
                FN_AND:  alu_fn = ALU_AND;
                FN_OR:   alu_fn = ALU_OR;
                FN_SLT:  alu_fn = ALU_SUB;
                default: alu_fn = ALU_ADD;
            endcase
        end else begin
            case (alu_cls[1:0])
                ACLS_ORI[1:0]: alu_fn = ALU_OR;
                ACLS_BEQ[1:0]: alu_fn = ALU_SUB;
                default:       alu_fn = ALU_ADD;
            endcase
        end
    end

endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_fn_e      fn,
    output logic [W-1:0] res,
    output logic         is_zero
);

    always_comb begin
        case (fn)
            ALU_SUB: res = opa - opb;
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            default: res = opa + opb;
        endcase
    end

    assign is_zero = (res == '0);

endmodule

// File: rtl/reg_file.sv
module reg_file #(
    parameter int W     = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  ra_data,
    output logic [W-1:0]  rb_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);

    logic [W-1:0] regs_d [NREGS];
    logic [W-1:0] regs_q [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (wr_addr != '0)) begin
            regs_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data = (ra_addr == '0) ? '0 : regs_q[ra_addr];
    assign rb_data = (rb_addr == '0) ? '0 : regs_q[rb_addr];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import core_pkg::*;
#(
    parameter int               NREGS    = 32,
    parameter logic [XLEN-1:0]  RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t state_d, state_q;

    logic [5:0]        opcode;
    logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
    logic [15:0]       imm16;
    logic [25:0]       jtarget;
    logic [3:0]        func_lo;
    logic              unused_bits;

    ctrl_t             ctrl;
    alu_fn_e           alu_fn;
    logic [XLEN-1:0]   rs_val, rt_val, ext_imm, opb, alu_res, wb_val;
    logic [XLEN-1:0]   pc_plus4, br_off;
    logic              alu_zero;

    assign opcode      = imem_data[31:26];
    assign rs_idx      = imem_data[25:21];
    assign rt_idx      = imem_data[20:16];
    assign rd_idx      = imem_data[15:11];
    assign imm16       = imem_data[15:0];
    assign jtarget     = imem_data[25:0];
    assign func_lo     = imem_data[3:0];
    assign unused_bits = ^imem_data[10:4];

    main_decoder u_main_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    alu_decoder u_alu_dec (
        .alu_cls (ctrl.alu_cls),
        .func_lo (func_lo),
        .alu_fn  (alu_fn)
    );

    reg_file #(.W(XLEN), .NREGS(NREGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (rs_idx),
        .rb_addr (rt_idx),
        .ra_data (rs_val),
        .rb_data (rt_val),
        .wr_en   (ctrl.reg_we),
        .wr_addr (wr_idx),
        .wr_data (wb_val)
    );

    assign ext_imm = ctrl.imm_signed ? {{(XLEN-16){imm16[15]}}, imm16}
                                     : {{(XLEN-16){1'b0}}, imm16};
    assign opb     = ctrl.opb_is_imm ? ext_imm : rt_val;

    core_alu #(.W(XLEN)) u_alu (
        .opa     (rs_val),
        .opb     (opb),
        .fn      (alu_fn),
        .res     (alu_res),
        .is_zero (alu_zero)
    );

    assign wr_idx = ctrl.dst_is_rd ? rd_idx : rt_idx;
    assign wb_val = ctrl.wb_from_mem ? dmem_rdata : alu_res;

    always_comb begin
        state_d  = state_q;
        pc_plus4 = state_q.pc + XLEN'(4);
        br_off   = {ext_imm[XLEN-3:0], 2'b00};
        case (ctrl.npc_sel)
            NPC_BR:  state_d.pc = alu_zero ? (pc_plus4 + br_off) : pc_plus4;
            NPC_JMP: state_d.pc = {pc_plus4[XLEN-1:XLEN-4], jtarget, 2'b00};
            default: state_d.pc = pc_plus4;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.pc <= RESET_PC;
        end else begin
            state_q <= state_d;
        end
    end

    assign imem_addr  = state_q.pc;
    assign dmem_addr  = alu_res;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we & rst_n;

endmodule

// File: rtl/core_checker.sv
module core_checker
    import core_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] imem_addr,
    input logic [31:0]     imem_data,
    input logic            dmem_we,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic [2:0]      alu_cls
);

    logic [5:0] op;
    logic       beq_taken;

    assign op        = imem_data[31:26];
    assign beq_taken = (op == OPC_BEQ) && (rs_val == rt_val);

    // R1: reset holds the PC at zero
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_pc: assert (imem_addr == '0);
        end
    end

    a_r1_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (!beq_taken && op != OPC_JMP) |=> imem_addr == $past(imem_addr) + 32'd4);

    a_r7_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
        beq_taken |=> imem_addr == $past(imem_addr) + 32'd4 +
            {{14{$past(imem_data[15])}}, $past(imem_data[15:0]), 2'b00});

    a_r8_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OPC_JMP) |=> imem_addr ==
            {$past(imem_addr[31:28] + 4'(imem_addr[27:2] == 26'h3FFFFFF)),
             $past(imem_data[25:0]), 2'b00});

    a_r6_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (op == OPC_STORE));

    a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_data[25:21] == 5'd0) |-> (rs_val == '0));

    a_r10_rtype_class: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OPC_RTYPE || op == OPC_ORI || op == OPC_LOAD || op == OPC_STORE || op == OPC_BEQ)
            |-> (alu_cls[2] == (op == OPC_RTYPE)));

endmodule

bind sc_core core_checker u_core_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .alu_cls   (ctrl.alu_cls)
);

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;

    localparam logic [5:0] T_RT = 6'b000000, T_ORI = 6'b001101, T_LW = 6'b100011,
                           T_SW = 6'b101011, T_BEQ = 6'b000100, T_J = 6'b000010;

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {T_RT, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    localparam int PLEN = 33;
    localparam logic [31:0] PROG [PLEN] = '{
        enc_i(T_ORI, 0, 1, 16'h8004),          //  0 r1 = 0x8004 (zero-extended)
        enc_i(T_ORI, 0, 2, 16'h0010),          //  1 r2 = 0x10
        enc_i(T_LW,  2, 3, 16'hFFFC),          //  2 r3 = mem[0x0C], negative offset
        enc_r(1, 3, 4, 6'b100000),             //  3 add
        enc_r(3, 1, 5, 6'b100010),             //  4 sub
        enc_r(1, 3, 6, 6'b100100),             //  5 and
        enc_r(1, 3, 7, 6'b100101),             //  6 or
        enc_r(3, 1, 8, 6'b101010),             //  7 set-less-than (subtract)
        enc_r(1, 2, 9, 6'b010000),             //  8 add, func bits 5:4 changed
        enc_r(1, 2, 10, 6'b000010),            //  9 sub, func bits 5:4 changed
        enc_i(T_ORI, 0, 0, 16'h00FF),          // 10 write to r0
        enc_i(T_BEQ, 1, 2, 16'h0005),          // 11 not taken
        enc_i(T_BEQ, 4, 4, 16'h0002),          // 12 taken to word 15
        enc_i(T_ORI, 0, 11, 16'h0BAD),         // 13 skipped
        enc_i(T_ORI, 0, 11, 16'h0BAD),         // 14 skipped
        {T_J, 26'd18},                         // 15 jump to word 18
        enc_i(T_ORI, 0, 12, 16'h0BAD),         // 16 skipped
        enc_i(T_ORI, 0, 12, 16'h0BAD),         // 17 skipped
        enc_i(T_SW, 0, 0, 16'h0020),           // 18 mem[8] = r0
        enc_i(T_SW, 2, 1, 16'h0034),           // 19..30 mem[16+k] = rk
        enc_i(T_SW, 2, 2, 16'h0038),
        enc_i(T_SW, 2, 3, 16'h003C),
        enc_i(T_SW, 2, 4, 16'h0040),
        enc_i(T_SW, 2, 5, 16'h0044),
        enc_i(T_SW, 2, 6, 16'h0048),
        enc_i(T_SW, 2, 7, 16'h004C),
        enc_i(T_SW, 2, 8, 16'h0050),
        enc_i(T_SW, 2, 9, 16'h0054),
        enc_i(T_SW, 2, 10, 16'h0058),
        enc_i(T_SW, 2, 11, 16'h005C),
        enc_i(T_SW, 2, 12, 16'h0060),
        enc_i(T_SW, 2, 1, 16'hFFF0),           // 31 mem[0] = r1, negative offset
        enc_i(T_BEQ, 0, 0, 16'hFFFF)           // 32 branch to itself
    };

    logic        clk;
    logic        rst_n;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic [31:0] m_mem [64];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    sc_core i_sc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            T_RT:    return "R2";
            T_ORI:   return "R4";
            T_LW:    return "R5";
            T_SW:    return "R6";
            T_BEQ:   return "R7";
            T_J:     return "R8";
            default: return "R1";
        endcase
    endfunction

    // instruction-level reference model, one instruction per call
    task automatic model_step();
        logic [31:0] ins, a, b, sx, zx, npc, res;
        logic [5:0]  op;
        int          dst;
        ins = imem[m_pc[7:2]];
        op  = ins[31:26];
        a   = m_rf[ins[25:21]];
        b   = m_rf[ins[20:16]];
        sx  = {{16{ins[15]}}, ins[15:0]};
        zx  = {16'h0, ins[15:0]};
        npc = m_pc + 32'd4;
        dst = 0;
        res = '0;
        case (op)
            T_RT: begin
                dst = int'(ins[15:11]);
                case (ins[3:0])
                    4'b0010, 4'b1010: res = a - b;
                    4'b0100:          res = a & b;
                    4'b0101:          res = a | b;
                    default:          res = a + b;
                endcase
            end
            T_ORI: begin dst = int'(ins[20:16]); res = a | zx; end
            T_LW:  begin dst = int'(ins[20:16]); res = m_mem[5'(0) + 6'((a + sx) >> 2)]; end
            T_SW:  m_mem[6'((a + sx) >> 2)] = b;
            T_BEQ: if (a == b) npc = npc + {sx[29:0], 2'b00};
            T_J:   npc = {npc[31:28], ins[25:0], 2'b00};
            default: ;
        endcase
        if (dst != 0) m_rf[dst] = res;
        m_pc = npc;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        string prev_tag;
        logic [5:0] cur_op;
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) begin
            imem[i]  = (i < PLEN) ? PROG[i] : 32'h0;
            dmem[i]  = 32'h0;
            m_mem[i] = 32'h0;
        end
        dmem[3]  = 32'hF0F01234;
        m_mem[3] = 32'hF0F01234;
        for (int i = 0; i < 32; i++) m_rf[i] = 32'h0;
        m_pc = 32'h0;

        repeat (2) @(negedge clk);
        #1;
        chk(imem_addr == 32'h0, "R1", "PC in reset", imem_addr, 32'h0);
        chk(dmem_we == 1'b0, "R6", "store strobe in reset", {31'h0, dmem_we}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        prev_tag = "R1";
        for (int c = 0; c < 40; c++) begin
            cur_op = imem[m_pc[7:2]][31:26];
            chk(imem_addr == m_pc, prev_tag, "PC", imem_addr, m_pc);
            chk(dmem_we == (cur_op == T_SW), "R6", "store strobe",
                {31'h0, dmem_we}, {31'h0, cur_op == T_SW});
            if (cur_op == T_SW) begin
                logic [31:0] ins, ea;
                ins = imem[m_pc[7:2]];
                ea  = m_rf[ins[25:21]] + {{16{ins[15]}}, ins[15:0]};
                chk(dmem_addr == ea, "R6", "store address", dmem_addr, ea);
                chk(dmem_wdata == m_rf[ins[20:16]], "R6", "store data", dmem_wdata, m_rf[ins[20:16]]);
            end
            prev_tag = tag_of(cur_op);
            model_step();
            @(negedge clk);
            #1;
        end

        for (int i = 0; i < 64; i++) begin
            chk(dmem[i] == m_mem[i], "R6", $sformatf("memory word %0d vs model", i), dmem[i], m_mem[i]);
        end

        // directed values worked out by hand
        chk(dmem[17] == 32'h00008004, "R4", "or-immediate zero-extends", dmem[17], 32'h00008004);
        chk(dmem[18] == 32'h00000010, "R4", "or-immediate small", dmem[18], 32'h00000010);
        chk(dmem[19] == 32'hF0F01234, "R5", "load negative offset", dmem[19], 32'hF0F01234);
        chk(dmem[3]  == 32'hF0F01234, "R5", "load leaves memory", dmem[3], 32'hF0F01234);
        chk(dmem[20] == 32'hF0F09238, "R2", "add", dmem[20], 32'hF0F09238);
        chk(dmem[21] == 32'hF0EF9230, "R2", "subtract", dmem[21], 32'hF0EF9230);
        chk(dmem[22] == 32'h00000004, "R2", "and", dmem[22], 32'h00000004);
        chk(dmem[23] == 32'hF0F09234, "R2", "or", dmem[23], 32'hF0F09234);
        chk(dmem[24] == 32'hF0EF9230, "R2", "set-less-than acts as subtract", dmem[24], 32'hF0EF9230);
        chk(dmem[25] == 32'h00008014, "R3", "func 010000 adds", dmem[25], 32'h00008014);
        chk(dmem[26] == 32'h00007FF4, "R3", "func 000010 subtracts", dmem[26], 32'h00007FF4);
        chk(dmem[8]  == 32'h0, "R9", "register 0 after write", dmem[8], 32'h0);
        chk(dmem[27] == 32'h0, "R7", "taken branch skipped words", dmem[27], 32'h0);
        chk(dmem[28] == 32'h0, "R8", "jump skipped words", dmem[28], 32'h0);
        chk(dmem[0]  == 32'h00008004, "R6", "store negative offset", dmem[0], 32'h00008004);
        chk(imem_addr == 32'h00000080, "R7", "backward self-branch holds PC", imem_addr, 32'h00000080);
        chk(m_pc == 32'h00000080, "R10", "model agrees on loop address", m_pc, 32'h00000080);

        // reset asserted in the middle of a run
        rst_n = 1'b0;
        #1;
        chk(imem_addr == 32'h0, "R1", "PC after mid-run reset", imem_addr, 32'h0);
        chk(dmem_we == 1'b0, "R6", "store strobe after mid-run reset", {31'h0, dmem_we}, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule